// File: doc/BRIEF.md
# Supervisor Mode Controller with Guarded Debug Entry

This block sequences the operating modes of a power-supervisor companion chip. After power-up it holds the system in a Reset mode that asserts a reset request. It then opens a timed Normal Request window, in which host software must configure the device through register writes. From Normal it can move to Standby, Stop or Sleep. A rising edge on chip-select wakes it from the two low-power modes. If the window closes with no configuration write, the block falls back to Reset and tries again.

A debug mode turns off the software watchdog so that host firmware can be stepped without being reset. Stray writes must not reach it by accident. It is entered only through a fixed run of three writes inside one Normal Request window, and only while a battery-fail flag is still set from power-up. Software that never wants debug reads the mode control register, which clears that flag. Debug survives Stop and Sleep. Waking from either debug low-power mode reopens the Normal Request window, in which the next debug mode has to be chosen. The host side delivers already-decoded register write strobes with an address and a four-bit data field, together with a read strobe and a millisecond tick.

Top module: `supv_mode_ctrl`

## Requirements
- R1: The first clock with `rst` high, and any clock with `por_i` high, put the block in Reset mode (mode code 0) with `rst_req_o`=1, `batfail_o`=1 and `wd_en_o`=1. Reset mode lasts RST_TICKS ticks and then moves to Normal Request (code 1) with `rst_req_o`=0.
- R2: Normal Request lasts NREQ_TICKS ticks. The tick that ends it with no timing-register write (address 2) moves the block back to Reset, which then re-enters Normal Request.
- R3: A write to the timing register in Normal Request moves the block to Normal (code 2) on the next cycle. Outside debug, mode control writes (address 0) in Normal Request are ignored.
- R4: In Normal or Standby, a mode control write selects the mode from data bits [2:0]: 001 Normal, 010 Standby (code 3), 011 Stop (code 4), 100 Sleep (code 5), 101 Normal. Codes 000, 110 and 111 leave the mode unchanged, and data bit 3 is ignored.
- R5: Debug entry turns the watchdog off (`wd_en_o`=0) and leaves the mode at Normal. It needs three consecutive writes: a timing-register write in Normal Request, then a mode control write of data 0000 while `batfail_o` is 1, then a mode control write with data bits [2:0]=101. All three must fall within NREQ_TICKS ticks of entering Normal Request.
- R6: Any other write between the first and the last step of the debug entry aborts it, and so does the window's last tick. After an abort the watchdog stays enabled.
- R7: A mode control read (`rd_stb_i` with address 0) clears `batfail_o`. With the flag clear, the debug entry writes leave the watchdog enabled.
- R8: A mode control write of data 0000 while in debug re-enables the watchdog on the next cycle and does not change the mode.
- R9: A low-to-high edge of `cs_i` is a wake-up in Stop or Sleep and is ignored in all other modes. Stop wakes to Normal Request. Sleep wakes to Reset, or to Normal Request when in debug. A falling edge never wakes the block.
- R10: In Normal Request while in debug, mode control codes 001 and 010 select Normal and Standby with the watchdog still off. If the window expires instead, the block enters Reset and debug is cleared (`wd_en_o`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, treated as a power-up |
| por_i | input | 1 | Power-on indication |
| tick_i | input | 1 | One-cycle millisecond tick strobe |
| wr_stb_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address (0 mode control, 2 timing) |
| wr_data_i | input | 4 | Write data field |
| rd_stb_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Read register address |
| cs_i | input | 1 | Chip-select level, rising edge is a wake-up |
| mode_o | output | 3 | Current mode code |
| rst_req_o | output | 1 | Reset request, high in Reset mode |
| wd_en_o | output | 1 | Software watchdog enable, low in debug |
| batfail_o | output | 1 | Battery-fail flag |

## Verification
Some checks run on every cycle. Reset mode may only be left for Normal Request. Stop may only be left through a chip-select edge into Normal Request. The watchdog may only turn off straight out of the armed step of the debug entry, and only turn back on after a clearing write, a power-on or a return to Reset. The battery-fail flag may only be raised by a power-on, and the window counter never runs past its limit. Only the bench scenarios can show the rest. These cover the exact tick on which a window closes, entry with one tick to spare against entry one tick too late, an abort by a foreign write, and the lockout after a flag read. They also cover the debug Stop and Sleep wake-up chain and the mode code table.

// File: rtl/supv_mode_pkg.sv
package supv_mode_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 4;

    localparam logic [ADDR_W-1:0] REG_MCTL = 3'd0;
    localparam logic [ADDR_W-1:0] REG_TIMG = 3'd2;

    typedef enum logic [2:0] {
        MODE_RESET   = 3'd0,
        MODE_NREQ    = 3'd1,
        MODE_NORMAL  = 3'd2,
        MODE_STANDBY = 3'd3,
        MODE_STOP    = 3'd4,
        MODE_SLEEP   = 3'd5
    } mode_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TIMED = 2'd1,
        SEQ_ARMED = 2'd2
    } seq_t;

    typedef struct packed {
        logic              mctl;
        logic              timg;
        logic              other;
        logic [DATA_W-1:0] data;
    } wr_evt_t;

    function automatic logic is_clear_code(logic [DATA_W-1:0] d);
        return d == 4'b0000;
    endfunction

    function automatic logic is_debug_code(logic [DATA_W-1:0] d);
        return d[2:0] == 3'b101;
    endfunction

    function automatic mode_t code_to_mode(logic [2:0] c, mode_t cur);
        case (c)
            3'b001:  return MODE_NORMAL;
            3'b010:  return MODE_STANDBY;
            3'b011:  return MODE_STOP;
            3'b100:  return MODE_SLEEP;
            3'b101:  return MODE_NORMAL;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/supv_wake_det.sv
module supv_wake_det (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    output logic rise_o
);
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) cs_q <= 1'b1;
        else     cs_q <= cs_i;
    end

    assign rise_o = cs_i & ~cs_q;

endmodule

// File: rtl/supv_tick_timer.sv
module supv_tick_timer #(
    parameter int RST_TICKS  = 1,
    parameter int NREQ_TICKS = 350
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    input  logic tick_i,
    input  logic long_i,
    output logic hit_o
);
    localparam int LIM_MAX = (NREQ_TICKS > RST_TICKS) ? NREQ_TICKS : RST_TICKS;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);
    localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_TICKS - 1);
    localparam logic [CNT_W-1:0] NREQ_LAST = CNT_W'(NREQ_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last  = long_i ? NREQ_LAST : RST_LAST;
    assign hit_o = run_i & tick_i & (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (run_i && tick_i && (cnt_q != last))
            cnt_q <= cnt_q + 1'b1;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(LIM_MAX - 1));

endmodule

// File: rtl/supv_dbg_seq.sv
module supv_dbg_seq
    import supv_mode_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    por_i,
    input  logic    in_nreq_i,
    input  logic    enter_reset_i,
    input  logic    win_hit_i,
    input  wr_evt_t wr_i,
    input  logic    batfail_i,
    output logic    dbg_o,
    output logic    busy_o
);
    seq_t seq_q, seq_d;
    logic dbg_q, dbg_d;
    logic any_wr;

    assign any_wr = wr_i.mctl | wr_i.timg | wr_i.other;

    always_comb begin
        seq_d = seq_q;
        dbg_d = dbg_q;
        if (por_i || enter_reset_i) begin
            seq_d = SEQ_IDLE;
            dbg_d = 1'b0;
        end else begin
            if (wr_i.mctl && is_clear_code(wr_i.data) && dbg_q)
                dbg_d = 1'b0;
            case (seq_q)
                SEQ_IDLE: begin
                    if (in_nreq_i && wr_i.timg && !dbg_q)
                        seq_d = SEQ_TIMED;
                end
                SEQ_TIMED: begin
                    if (win_hit_i)
                        seq_d = SEQ_IDLE;
                    else if (wr_i.mctl && is_clear_code(wr_i.data) && batfail_i)
                        seq_d = SEQ_ARMED;
                    else if (any_wr)
                        seq_d = SEQ_IDLE;
                end
                SEQ_ARMED: begin
                    if (win_hit_i)
                        seq_d = SEQ_IDLE;
                    else if (wr_i.mctl && is_debug_code(wr_i.data)) begin
                        seq_d = SEQ_IDLE;
                        dbg_d = 1'b1;
                    end else if (any_wr)
                        seq_d = SEQ_IDLE;
                end
                default: seq_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_IDLE;
            dbg_q <= 1'b0;
        end else begin
            seq_q <= seq_d;
            dbg_q <= dbg_d;
        end
    end

    assign dbg_o  = dbg_q;
    assign busy_o = (seq_q != SEQ_IDLE);

    // R5
    dbg_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_q) |-> ($past(seq_q) == SEQ_ARMED));

    // R8
    dbg_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dbg_q) |-> $past(por_i || enter_reset_i || (wr_i.mctl && (wr_i.data == 4'b0000))));

endmodule

// File: rtl/supv_mode_ctrl.sv
module supv_mode_ctrl
    import supv_mode_pkg::*;
#(
    parameter int RST_TICKS  = 1,
    parameter int NREQ_TICKS = 350
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_i,
    input  logic       tick_i,
    input  logic       wr_stb_i,
    input  logic [2:0] wr_addr_i,
    input  logic [3:0] wr_data_i,
    input  logic       rd_stb_i,
    input  logic [2:0] rd_addr_i,
    input  logic       cs_i,
    output logic [2:0] mode_o,
    output logic       rst_req_o,
    output logic       wd_en_o,
    output logic       batfail_o
);
    mode_t   mode_q, mode_d;
    wr_evt_t wr;
    logic    batfail_q;
    logic    dbg, busy, wake, hit;
    logic    clr, run, long_win, enter_reset;

    always_comb begin
        wr.mctl  = wr_stb_i && (wr_addr_i == REG_MCTL);
        wr.timg  = wr_stb_i && (wr_addr_i == REG_TIMG);
        wr.other = wr_stb_i && (wr_addr_i != REG_MCTL) && (wr_addr_i != REG_TIMG);
        wr.data  = wr_data_i;
    end

    always_comb begin
        mode_d = mode_q;
        if (por_i) begin
            mode_d = MODE_RESET;
        end else begin
            case (mode_q)
                MODE_RESET: begin
                    if (hit) mode_d = MODE_NREQ;
                end
                MODE_NREQ: begin
                    if (wr.timg)
                        mode_d = MODE_NORMAL;
                    else if (wr.mctl && dbg &&
                             (wr.data[2:0] == 3'b001 || wr.data[2:0] == 3'b010))
                        mode_d = code_to_mode(wr.data[2:0], mode_q);
                    else if (hit)
                        mode_d = MODE_RESET;
                end
                MODE_NORMAL, MODE_STANDBY: begin
                    if (wr.mctl) mode_d = code_to_mode(wr.data[2:0], mode_q);
                end
                MODE_STOP: begin
                    if (wake) mode_d = MODE_NREQ;
                end
                MODE_SLEEP: begin
                    if (wake) mode_d = dbg ? MODE_NREQ : MODE_RESET;
                end
                default: mode_d = MODE_RESET;
            endcase
        end
    end

    assign enter_reset = (mode_d == MODE_RESET) && (mode_q != MODE_RESET);
    assign clr         = por_i || ((mode_d != mode_q) &&
                         (mode_d == MODE_RESET || mode_d == MODE_NREQ));
    assign run         = (mode_q == MODE_RESET) || (mode_q == MODE_NREQ) ||
                         ((mode_q == MODE_NORMAL) && busy);
    assign long_win    = (mode_q != MODE_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_RESET;
            batfail_q <= 1'b1;
        end else begin
            mode_q <= mode_d;
            if (por_i)
                batfail_q <= 1'b1;
            else if (rd_stb_i && (rd_addr_i == REG_MCTL))
                batfail_q <= 1'b0;
        end
    end

    supv_wake_det u_wake (
        .clk    (clk),
        .rst    (rst),
        .cs_i   (cs_i),
        .rise_o (wake)
    );

    supv_tick_timer #(
        .RST_TICKS  (RST_TICKS),
        .NREQ_TICKS (NREQ_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .run_i  (run),
        .tick_i (tick_i),
        .long_i (long_win),
        .hit_o  (hit)
    );

    supv_dbg_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .por_i         (por_i),
        .in_nreq_i     (mode_q == MODE_NREQ),
        .enter_reset_i (enter_reset),
        .win_hit_i     (hit),
        .wr_i          (wr),
        .batfail_i     (batfail_q),
        .dbg_o         (dbg),
        .busy_o        (busy)
    );

    assign mode_o    = mode_q;
    assign rst_req_o = (mode_q == MODE_RESET);
    assign wd_en_o   = ~dbg;
    assign batfail_o = batfail_q;

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(mode_q) == MODE_RESET) && (mode_q != MODE_RESET)) |-> (mode_q == MODE_NREQ));

    // R3
    normal_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(mode_q) == MODE_NREQ) && (mode_q == MODE_NORMAL)) |-> $past(wr_stb_i));

    // R9
    stop_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(mode_q) == MODE_STOP) && (mode_q != MODE_STOP) && !$past(por_i))
        |-> ((mode_q == MODE_NREQ) && $past(cs_i)));

    // R7
    batfail_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(batfail_q) |-> $past(por_i));

endmodule

// File: tb/supv_mode_ctrl_test.sv
`timescale 1ns/1ps
module supv_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_stb_i = 1'b0;
    logic [2:0] wr_addr_i = 3'd0;
    logic [3:0] wr_data_i = 4'd0;
    logic       rd_stb_i = 1'b0;
    logic [2:0] rd_addr_i = 3'd0;
    logic       cs_i = 1'b1;
    logic [2:0] mode_o;
    logic       rst_req_o, wd_en_o, batfail_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    supv_mode_ctrl uut (
        .clk(clk), .rst(rst), .por_i(por_i), .tick_i(tick_i),
        .wr_stb_i(wr_stb_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_stb_i(rd_stb_i), .rd_addr_i(rd_addr_i), .cs_i(cs_i),
        .mode_o(mode_o), .rst_req_o(rst_req_o), .wd_en_o(wd_en_o),
        .batfail_o(batfail_o)
    );

    // rows: [7:4] mode control data, [2:0] expected mode code
    localparam logic [7:0] CODE_TBL [9] = '{
        8'h23, 8'h92, 8'hA3, 8'h52, 8'h62, 8'h72, 8'h02, 8'hA3, 8'h12
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        wr_stb_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_stb_i = 1'b0;
    endtask

    task automatic rd_mctl();
        rd_stb_i = 1'b1; rd_addr_i = 3'd0;
        @(negedge clk);
        rd_stb_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
        end
        tick_i = 1'b0;
    endtask

    task automatic cs_pulse();
        cs_i = 1'b0;
        @(negedge clk);
        cs_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic enter_debug(input logic [3:0] last_code);
        wr(3'd2, 4'h0);
        wr(3'd0, 4'h0);
        wr(3'd0, last_code);
    endtask

    task automatic stop_to_nreq();
        wr(3'd0, 4'b0011);
        cs_pulse();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mode", mode_o, 0);
        chk("R1 reset req", rst_req_o, 1);
        chk("R1 reset batfail", batfail_o, 1);
        chk("R1 reset wd", wd_en_o, 1);
        ticks(1);
        chk("R1 to nreq", mode_o, 1);
        chk("R1 req released", rst_req_o, 0);

        ticks(349);
        chk("R2 window open", mode_o, 1);
        ticks(1);
        chk("R2 timeout reset", mode_o, 0);
        ticks(1);
        chk("R2 nreq again", mode_o, 1);

        wr(3'd0, 4'b0001);
        chk("R3 mctl ignored", mode_o, 1);
        wr(3'd2, 4'h0);
        chk("R3 timing to normal", mode_o, 2);

        for (int i = 0; i < 9; i++) begin
            wr(3'd0, CODE_TBL[i][7:4]);
            chk($sformatf("R4 row %0d mode", i), mode_o, int'(CODE_TBL[i][2:0]));
            chk($sformatf("R4 row %0d wd", i), wd_en_o, 1);
        end

        cs_i = 1'b0; @(negedge clk); cs_i = 1'b1; @(negedge clk);
        chk("R9 cs in normal", mode_o, 2);
        wr(3'd0, 4'b0011);
        chk("R4 stop", mode_o, 4);
        cs_i = 1'b0; @(negedge clk);
        chk("R9 falling ignored", mode_o, 4);
        cs_i = 1'b1; @(negedge clk);
        chk("R9 stop wake", mode_o, 1);
        wr(3'd2, 4'h0);
        wr(3'd0, 4'b0100);
        chk("R4 sleep", mode_o, 5);
        cs_pulse();
        chk("R9 sleep wake reset", mode_o, 0);
        ticks(1);

        wr(3'd2, 4'h0);
        wr(3'd0, 4'h0);
        chk("R5 armed wd still on", wd_en_o, 1);
        wr(3'd0, 4'b1101);
        chk("R5 debug wd off", wd_en_o, 0);
        chk("R5 debug mode", mode_o, 2);

        wr(3'd0, 4'b0011);
        cs_pulse();
        chk("R9 debug stop wake", mode_o, 1);
        chk("R10 wd off after wake", wd_en_o, 0);
        wr(3'd0, 4'b0010);
        chk("R10 debug standby", mode_o, 3);
        chk("R10 debug standby wd", wd_en_o, 0);
        wr(3'd0, 4'b0100);
        cs_pulse();
        chk("R9 debug sleep wake", mode_o, 1);
        ticks(350);
        chk("R10 timeout reset", mode_o, 0);
        chk("R10 debug cleared", wd_en_o, 1);
        ticks(1);

        enter_debug(4'b0101);
        chk("R8 in debug", wd_en_o, 0);
        wr(3'd0, 4'h0);
        chk("R8 exit wd on", wd_en_o, 1);
        chk("R8 exit mode", mode_o, 2);

        stop_to_nreq();
        wr(3'd2, 4'h0);
        wr(3'd3, 4'h0);
        wr(3'd0, 4'h0);
        wr(3'd0, 4'b0101);
        chk("R6 foreign write abort", wd_en_o, 1);

        stop_to_nreq();
        ticks(100);
        wr(3'd2, 4'h0);
        wr(3'd0, 4'h0);
        ticks(249);
        wr(3'd0, 4'b0101);
        chk("R5 last tick in window", wd_en_o, 0);
        wr(3'd0, 4'h0);

        stop_to_nreq();
        ticks(100);
        wr(3'd2, 4'h0);
        wr(3'd0, 4'h0);
        ticks(250);
        wr(3'd0, 4'b0101);
        chk("R6 window expired", wd_en_o, 1);
        chk("R6 mode", mode_o, 2);

        rd_mctl();
        chk("R7 read clears flag", batfail_o, 0);
        stop_to_nreq();
        enter_debug(4'b0101);
        chk("R7 locked out", wd_en_o, 1);

        por_i = 1'b1; @(negedge clk); por_i = 1'b0;
        chk("R1 por mode", mode_o, 0);
        chk("R1 por batfail", batfail_o, 1);
        chk("R1 por req", rst_req_o, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule